// File: doc/BRIEF.md
# Two-Wire Bus Master Command Engine

This block is a byte-level master for an I2C-style two-wire bus. Software, or a DMA channel, writes one command: a start request, a direction bit, a 7-bit target address and a byte count. The engine then runs the whole transfer without any per-bit help. It sends the START condition, the address byte with its direction bit and the data bytes, checks or drives each acknowledge bit, and finishes with a STOP.

Data moves through two single-byte holding registers, one for transmit and one for receive. The engine stalls the bus clock, holding SCL low, whenever the next byte cannot proceed: in write mode because the transmit register is empty, and in read mode because the receive register has not been read yet. Six status flags report progress, and each flag has its own interrupt enable.

Both bus lines are open drain. They are modelled as drive-low enables, and the resolved line levels come back in through two inputs.

Top module: `twi_master_engine`

## Requirements
- R1: After reset the engine drives neither bus line low. idle_o and tx_rdy_o are 1. rx_rdy_o, ccomp_o, anak_o, dnak_o and irq_o are 0.
- R2: A command pulse on cmd_valid_i is accepted only when the engine is idle and both bus lines read high. Otherwise it is ignored: no line is driven and idle_o stays 1.
- R3: A transfer opens with SDA pulled low while SCL is released. The 8-bit address byte follows, MSB first, as the 7 address bits and then the direction bit (1 = read, 0 = write).
- R4: If SDA reads high at the end of the address acknowledge clock, anak_o is set and the engine sends a STOP with no data bytes.
- R5: In write mode, tx_rdy_o is 1 while the transmit register is empty. A write to it while full is ignored. While it is empty and bytes remain, SCL is held low between bytes.
- R6: In write mode, the data bytes go out MSB first in the order written. After the acknowledged byte that brings the count to zero, a STOP follows.
- R7: In write mode, a data byte that is not acknowledged sets dnak_o and ends the command with a STOP, even if bytes remain.
- R8: In read mode, each received byte is loaded into rx_data_o and sets rx_rdy_o. A pulse on rx_rd_i clears rx_rdy_o. While rx_rdy_o is 1 and bytes remain, SCL is held low before the next byte.
- R9: In read mode, the engine drives ACK (SDA low) after every byte except the one that brings the count to zero, which it follows with NAK (SDA released).
- R10: A STOP is SDA released while SCL is high. After it, idle_o and ccomp_o are set and no line is driven.
- R11: irq_o is the OR of the set flags whose enable bit in irq_en_i is 1. The bit positions are 0 tx_rdy, 1 rx_rdy, 2 idle, 3 ccomp, 4 anak, 5 dnak.
- R12: Accepting a command clears ccomp_o, anak_o and dnak_o, and drops idle_o.
- R13: Each SCL high phase and each unstretched SCL low phase lasts half_period_i clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_period_i | input | PRESC_W | SCL half-period in clock cycles |
| cmd_valid_i | input | 1 | Command start pulse |
| cmd_read_i | input | 1 | 1 = read transfer, 0 = write transfer |
| cmd_addr_i | input | 7 | Target address |
| cmd_nbytes_i | input | CNT_W | Number of data bytes |
| tx_wr_i | input | 1 | Write pulse for the transmit register |
| tx_data_i | input | 8 | Byte to transmit |
| tx_rdy_o | output | 1 | Transmit register empty; also the DMA transmit request |
| rx_rd_i | input | 1 | Read pulse for the receive register |
| rx_data_o | output | 8 | Last received byte |
| rx_rdy_o | output | 1 | Receive register holds an unread byte |
| idle_o | output | 1 | Engine idle, bus released |
| ccomp_o | output | 1 | Command complete |
| anak_o | output | 1 | Address not acknowledged |
| dnak_o | output | 1 | Write data not acknowledged |
| irq_en_i | input | 6 | Per-flag interrupt enables |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |

## Verification
The bench goes after several corner cases:
- A command issued while another device holds SDA low. An engine that ignored bus state would pull SCL and corrupt that traffic.
- An address the slave refuses. A design that went on to the data phase would log extra bytes and never set anak_o.
- Long pauses with the transmit register empty, and long pauses with an unread received byte. A design without stretching would clock out stale data or overwrite rx_data_o, and the bus slave model's byte log would run ahead.
- The acknowledge the master drives after each read byte. An off-by-one in the byte counter would NAK one byte early or ACK the last byte, and then the slave would keep driving data into the STOP.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned NFLAGS  = 6;
  localparam int unsigned BIT_W   = 4;

  localparam int unsigned FL_TXRDY = 0;
  localparam int unsigned FL_RXRDY = 1;
  localparam int unsigned FL_IDLE  = 2;
  localparam int unsigned FL_CCOMP = 3;
  localparam int unsigned FL_ANAK  = 4;
  localparam int unsigned FL_DNAK  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT_LO, ST_BIT_HI,
    ST_WAIT, ST_STOP_LO, ST_STOP_HI, ST_STOP_REL
  } twi_state_e;

  typedef enum logic [1:0] {PH_ADDR, PH_TX, PH_RX} twi_phase_e;
endpackage

// File: rtl/twi_tick_gen.sv
module twi_tick_gen #(
  parameter int unsigned PRESC_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [PRESC_W-1:0] half_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= (half_i == '0) ? '0 : half_i - PRESC_W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - PRESC_W'(1);
  end

  // phase ends in the cycle the count reaches zero
  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/twi_hold_regs.sv
module twi_hold_regs
  import twi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic              tx_full_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_push_data_i,
  input  logic              rx_rd_i,
  output logic              rx_full_o,
  output logic [DATA_W-1:0] rx_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_full_o <= 1'b0;
      tx_data_o <= '0;
    end else if (tx_pop_i) begin
      tx_full_o <= 1'b0;
    end else if (tx_wr_i && !tx_full_o) begin
      tx_full_o <= 1'b1;
      tx_data_o <= tx_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_o <= 1'b0;
      rx_data_o <= '0;
    end else if (rx_push_i) begin
      rx_full_o <= 1'b1;
      rx_data_o <= rx_push_data_i;
    end else if (rx_rd_i) begin
      rx_full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/twi_irq_ctrl.sv
module twi_irq_ctrl #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign hit[i] = flags_i[i] & en_i[i];
  end

  assign irq_o = |hit;
endmodule

// File: rtl/twi_master_engine.sv
module twi_master_engine
  import twi_pkg::*;
#(
  parameter int unsigned PRESC_W = 16,
  parameter int unsigned CNT_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PRESC_W-1:0]  half_period_i,
  input  logic                cmd_valid_i,
  input  logic                cmd_read_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [CNT_W-1:0]    cmd_nbytes_i,
  input  logic                tx_wr_i,
  input  logic [DATA_W-1:0]   tx_data_i,
  output logic                tx_rdy_o,
  input  logic                rx_rd_i,
  output logic [DATA_W-1:0]   rx_data_o,
  output logic                rx_rdy_o,
  output logic                idle_o,
  output logic                ccomp_o,
  output logic                anak_o,
  output logic                dnak_o,
  input  logic [NFLAGS-1:0]   irq_en_i,
  output logic                irq_o,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                scl_low_o,
  output logic                sda_low_o
);
  localparam logic [BIT_W-1:0] ACK_BIT  = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  twi_state_e          state_q, state_d;
  twi_phase_e          phase_q, phase_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [DATA_W-1:0]   shift_q, shift_d;
  logic [CNT_W-1:0]    rem_q, rem_d;
  logic                rd_mode_q, rd_mode_d;
  logic                idle_q, idle_d;
  logic                ccomp_q, ccomp_d;
  logic                anak_q, anak_d;
  logic                dnak_q, dnak_d;

  logic                tick, tx_pop, rx_push, tx_full, rx_full;
  logic [DATA_W-1:0]   tx_hold, rx_push_data;
  logic [NFLAGS-1:0]   flags;

  twi_tick_gen #(.PRESC_W(PRESC_W)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_d != state_q),
    .half_i (half_period_i),
    .tick_o (tick)
  );

  twi_hold_regs i_hold (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tx_wr_i        (tx_wr_i),
    .tx_data_i      (tx_data_i),
    .tx_pop_i       (tx_pop),
    .tx_full_o      (tx_full),
    .tx_data_o      (tx_hold),
    .rx_push_i      (rx_push),
    .rx_push_data_i (rx_push_data),
    .rx_rd_i        (rx_rd_i),
    .rx_full_o      (rx_full),
    .rx_data_o      (rx_data_o)
  );

  assign rx_push_data = {shift_q[DATA_W-2:0], sda_i};

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    bit_d     = bit_q;
    shift_d   = shift_q;
    rem_d     = rem_q;
    rd_mode_d = rd_mode_q;
    idle_d    = idle_q;
    ccomp_d   = ccomp_q;
    anak_d    = anak_q;
    dnak_d    = dnak_q;
    tx_pop    = 1'b0;
    rx_push   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i && scl_i && sda_i) begin
          state_d   = ST_START;
          phase_d   = PH_ADDR;
          rd_mode_d = cmd_read_i;
          rem_d     = cmd_nbytes_i;
          shift_d   = {cmd_addr_i, cmd_read_i};
          bit_d     = '0;
          idle_d    = 1'b0;
          ccomp_d   = 1'b0;
          anak_d    = 1'b0;
          dnak_d    = 1'b0;
        end
      end
      ST_START:  if (tick) state_d = ST_BIT_LO;
      ST_BIT_LO: if (tick) state_d = ST_BIT_HI;
      ST_BIT_HI: begin
        if (tick) begin
          if (bit_q != ACK_BIT) begin
            state_d = ST_BIT_LO;
            bit_d   = bit_q + BIT_W'(1);
            shift_d = {shift_q[DATA_W-2:0], (phase_q == PH_RX) ? sda_i : 1'b0};
            if (bit_q == LAST_BIT && phase_q != PH_ADDR) rem_d = rem_q - CNT_W'(1);
            if (bit_q == LAST_BIT && phase_q == PH_RX)   rx_push = 1'b1;
          end else begin
            unique case (phase_q)
              PH_ADDR: begin
                if (sda_i) begin
                  anak_d  = 1'b1;
                  state_d = ST_STOP_LO;
                end else if (rem_q == '0) begin
                  state_d = ST_STOP_LO;
                end else begin
                  phase_d = rd_mode_q ? PH_RX : PH_TX;
                  state_d = ST_WAIT;
                end
              end
              PH_TX: begin
                if (sda_i) begin
                  dnak_d  = 1'b1;
                  state_d = ST_STOP_LO;
                end else begin
                  state_d = (rem_q == '0) ? ST_STOP_LO : ST_WAIT;
                end
              end
              default: state_d = (rem_q == '0) ? ST_STOP_LO : ST_WAIT;
            endcase
          end
        end
      end
      ST_WAIT: begin
        // SCL stays low until the holding register is serviced
        if (phase_q == PH_RX) begin
          if (!rx_full) begin
            bit_d   = '0;
            state_d = ST_BIT_LO;
          end
        end else if (tx_full) begin
          tx_pop  = 1'b1;
          shift_d = tx_hold;
          bit_d   = '0;
          state_d = ST_BIT_LO;
        end
      end
      ST_STOP_LO: if (tick) state_d = ST_STOP_HI;
      ST_STOP_HI: if (tick) state_d = ST_STOP_REL;
      ST_STOP_REL: begin
        if (tick) begin
          state_d = ST_IDLE;
          idle_d  = 1'b1;
          ccomp_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bit_q     <= '0;
      shift_q   <= '0;
      rem_q     <= '0;
      rd_mode_q <= 1'b0;
      idle_q    <= 1'b1;
      ccomp_q   <= 1'b0;
      anak_q    <= 1'b0;
      dnak_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      bit_q     <= bit_d;
      shift_q   <= shift_d;
      rem_q     <= rem_d;
      rd_mode_q <= rd_mode_d;
      idle_q    <= idle_d;
      ccomp_q   <= ccomp_d;
      anak_q    <= anak_d;
      dnak_q    <= dnak_d;
    end
  end

  always_comb begin
    scl_low_o = (state_q == ST_BIT_LO) || (state_q == ST_WAIT) || (state_q == ST_STOP_LO);
    unique case (state_q)
      ST_START, ST_STOP_LO, ST_STOP_HI: sda_low_o = 1'b1;
      ST_BIT_LO, ST_BIT_HI:
        sda_low_o = (bit_q != ACK_BIT) ? ((phase_q != PH_RX) && !shift_q[DATA_W-1])
                                       : ((phase_q == PH_RX) && (rem_q != '0));
      default: sda_low_o = 1'b0;
    endcase
  end

  assign tx_rdy_o = !tx_full;
  assign rx_rdy_o = rx_full;
  assign idle_o   = idle_q;
  assign ccomp_o  = ccomp_q;
  assign anak_o   = anak_q;
  assign dnak_o   = dnak_q;

  always_comb begin
    flags           = '0;
    flags[FL_TXRDY] = tx_rdy_o;
    flags[FL_RXRDY] = rx_rdy_o;
    flags[FL_IDLE]  = idle_q;
    flags[FL_CCOMP] = ccomp_q;
    flags[FL_ANAK]  = anak_q;
    flags[FL_DNAK]  = dnak_q;
  end

  twi_irq_ctrl #(.N(NFLAGS)) i_irq (
    .flags_i (flags),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/twi_master_chk.sv
module twi_master_chk
  import twi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              scl_i,
  input logic              sda_i,
  input logic              idle_o,
  input logic              ccomp_o,
  input logic              anak_o,
  input logic              dnak_o,
  input logic              tx_rdy_o,
  input logic              rx_rdy_o,
  input logic              rx_rd_i,
  input logic              rx_push,
  input logic [NFLAGS-1:0] irq_en_i,
  input logic              irq_o,
  input logic              scl_low_o,
  input logic              sda_low_o,
  input twi_state_e        state_q,
  input twi_phase_e        phase_q
);
  // R2
  busy_bus_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && cmd_valid_i && !(scl_i && sda_i)) |=> idle_o);

  // R5
  tx_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && phase_q == PH_TX && tx_rdy_o) |-> scl_low_o);

  // R8
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rdy_o && rx_rd_i && !rx_push) |=> !rx_rdy_o);

  // R8
  rx_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && phase_q == PH_RX && rx_rdy_o) |-> scl_low_o);

  // R10
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!scl_low_o && !sda_low_o));

  // R10
  done_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> ccomp_o);

  // R11
  irq_ccomp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccomp_o && irq_en_i[FL_CCOMP]) |-> irq_o);

  // R12
  flags_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_o) |-> (!ccomp_o && !anak_o && !dnak_o));
endmodule

bind twi_master_engine twi_master_chk i_twi_master_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .idle_o      (idle_o),
  .ccomp_o     (ccomp_o),
  .anak_o      (anak_o),
  .dnak_o      (dnak_o),
  .tx_rdy_o    (tx_rdy_o),
  .rx_rdy_o    (rx_rdy_o),
  .rx_rd_i     (rx_rd_i),
  .rx_push     (rx_push),
  .irq_en_i    (irq_en_i),
  .irq_o       (irq_o),
  .scl_low_o   (scl_low_o),
  .sda_low_o   (sda_low_o),
  .state_q     (state_q),
  .phase_q     (phase_q)
);

// File: tb/test_twi_master_engine.sv
module test_twi_master_engine;
  localparam int unsigned PRESC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_nbytes = '0;
  logic       tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = '0;
  logic [5:0] irq_en = '0;
  logic       tx_rdy, rx_rdy, idle, ccomp, anak, dnak, irq, scl_low, sda_low;
  logic [7:0] rx_data;
  logic       sda_slave = 1'b0, sda_force = 1'b0;
  logic       scl_line, sda_line;

  int n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign scl_line = ~scl_low;
  assign sda_line = ~(sda_low | sda_slave | sda_force);

  twi_master_engine i_twi_master_engine (
    .clk_i(clk), .rst_ni(rst_n), .half_period_i(16'(PRESC)),
    .cmd_valid_i(cmd_valid), .cmd_read_i(cmd_read), .cmd_addr_i(cmd_addr),
    .cmd_nbytes_i(cmd_nbytes), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .tx_rdy_o(tx_rdy), .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_rdy_o(rx_rdy),
    .idle_o(idle), .ccomp_o(ccomp), .anak_o(anak), .dnak_o(dnak),
    .irq_en_i(irq_en), .irq_o(irq), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low)
  );

  // bus slave model, evaluated away from the active edge
  logic [6:0] slave_addr = 7'h5A;
  int         nack_at = -1;
  logic [7:0] rdata [4];
  logic [7:0] log_b [64];
  logic       mack [64];
  int nlog = 0, nmack = 0, nstop = 0;
  int bitn = 0, didx = 0, hi_cnt = 0, lo_cnt = 0, hi_len = 0, lo_len = 0;
  logic is_addr = 1'b0, addressed = 1'b0, s_read = 1'b0, last_ack = 1'b0;
  logic [7:0] sh = '0;
  logic scl_p = 1'b1, sda_p = 1'b1;

  always @(negedge clk) begin
    if (scl_p && scl_line && sda_p && !sda_line) begin
      bitn = 0; is_addr = 1'b1; didx = 0; addressed = 1'b0;
    end
    if (scl_p && scl_line && !sda_p && sda_line) begin
      nstop++; addressed = 1'b0; sda_slave = 1'b0;
    end
    if (scl_line) hi_cnt++; else lo_cnt++;
    if (!scl_p && scl_line) begin
      lo_len = lo_cnt; lo_cnt = 0;
      bitn++;
      if (bitn <= 8) sh = {sh[6:0], sda_line};
      if (bitn == 8) begin
        log_b[nlog % 64] = sh; nlog++;
        if (is_addr) begin
          addressed = (sh[7:1] == slave_addr);
          s_read = sh[0];
        end
      end
      if (bitn == 9 && !is_addr && s_read && addressed) begin
        mack[nmack % 64] = sda_line; nmack++; last_ack = !sda_line;
      end
    end
    if (scl_p && !scl_line) begin
      hi_len = hi_cnt; hi_cnt = 0;
      if (bitn == 8) begin
        sda_slave = 1'b0;
        if (addressed && (is_addr || (!s_read && didx != nack_at))) sda_slave = 1'b1;
      end else if (bitn == 9) begin
        sda_slave = 1'b0; bitn = 0;
        if (is_addr) begin
          is_addr = 1'b0;
          if (addressed && s_read) sda_slave = ~rdata[0][7];
        end else if (addressed && s_read) begin
          if (last_ack) begin
            didx++;
            sda_slave = ~rdata[didx % 4][7];
          end
        end else begin
          didx++;
        end
      end else if (bitn >= 1 && bitn <= 7 && !is_addr && addressed && s_read) begin
        sda_slave = ~rdata[didx % 4][7-bitn];
      end
    end
    scl_p = scl_line; sda_p = sda_line;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic rd, input logic [6:0] a, input logic [7:0] n);
    @(negedge clk);
    cmd_read = rd; cmd_addr = a; cmd_nbytes = n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && !idle; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R1 idle", idle, 1); chk("R1 tx_rdy", tx_rdy, 1); chk("R1 rx_rdy", rx_rdy, 0);
    chk("R1 flags", {ccomp, anak, dnak}, 0); chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_low, sda_low}, 0);
  endtask

  task automatic t_irq_mask();
    irq_en = 6'b000000; cyc(1);
    chk("R11 masked", irq, 0);
    irq_en = 6'b000100; cyc(1);
    chk("R11 idle enabled", irq, 1);
    irq_en = 6'b001000; cyc(1);
    chk("R11 ccomp clear", irq, 0);
  endtask

  task automatic t_busy();
    sda_force = 1'b1; cyc(2);
    issue(1'b0, 7'h5A, 8'd1);
    cyc(30);
    chk("R2 no drive", {scl_low, sda_low}, 0);
    chk("R2 still idle", idle, 1);
    sda_force = 1'b0; cyc(30);
    chk("R2 no late start", {scl_low, sda_low, idle}, 3'b001);
  endtask

  task automatic t_addr_nack();
    int b0 = nlog, s0 = nstop;
    issue(1'b0, 7'h33, 8'd2);
    cyc(1);
    chk("R12 idle drops", idle, 0);
    wait_idle(); cyc(2);
    chk("R3 addr byte", log_b[b0 % 64], 8'h66);
    chk("R4 anak", anak, 1);
    chk("R4 no data bytes", nlog - b0, 1);
    chk("R10 stop seen", nstop - s0, 1);
    chk("R10 ccomp", ccomp, 1);
    irq_en = 6'b010000; cyc(1);
    chk("R11 anak irq", irq, 1);
    irq_en = '0;
  endtask

  task automatic t_write();
    int b0 = nlog, s0 = nstop;
    push_tx(8'hA5);
    chk("R5 tx full", tx_rdy, 0);
    push_tx(8'hFF);
    issue(1'b0, 7'h5A, 8'd3);
    cyc(1);
    chk("R12 anak cleared", anak, 0);
    for (int i = 0; i < 2000 && nlog - b0 < 2; i++) @(negedge clk);
    cyc(60);
    chk("R5 held low", scl_low, 1);
    chk("R5 no byte run", nlog - b0, 2);
    chk("R5 tx_rdy empty", tx_rdy, 1);
    push_tx(8'h3C);
    for (int i = 0; i < 2000 && !tx_rdy; i++) @(negedge clk);
    push_tx(8'h01);
    irq_en = 6'b001000;
    wait_idle(); cyc(2);
    chk("R3 addr write", log_b[b0 % 64], 8'hB4);
    chk("R6 byte1", log_b[(b0 + 1) % 64], 8'hA5);
    chk("R6 byte2 (full write ignored)", log_b[(b0 + 2) % 64], 8'h3C);
    chk("R6 byte3", log_b[(b0 + 3) % 64], 8'h01);
    chk("R6 count", nlog - b0, 4);
    chk("R10 one stop", nstop - s0, 1);
    chk("R10 done flags", {ccomp, anak, dnak}, 3'b100);
    chk("R11 ccomp irq", irq, 1);
    chk("R13 high phase", hi_len, PRESC);
    chk("R13 low phase", lo_len, PRESC);
    irq_en = '0;
  endtask

  task automatic t_data_nack();
    int b0 = nlog, s0 = nstop;
    nack_at = 0;
    push_tx(8'h77);
    issue(1'b0, 7'h5A, 8'd3);
    wait_idle(); cyc(2);
    chk("R7 dnak", dnak, 1);
    chk("R7 stopped early", nlog - b0, 2);
    chk("R7 stop", nstop - s0, 1);
    chk("R7 ccomp", ccomp, 1);
    irq_en = 6'b100000; cyc(1);
    chk("R11 dnak irq", irq, 1);
    irq_en = '0;
    nack_at = -1;
  endtask

  task automatic t_read();
    int b0, m0 = nmack, s0 = nstop, held;
    rdata[0] = 8'hC3; rdata[1] = 8'h5E; rdata[2] = 8'h81; rdata[3] = 8'h00;
    b0 = nlog;
    issue(1'b1, 7'h5A, 8'd3);
    cyc(1);
    chk("R12 dnak cleared", dnak, 0);
    for (int i = 0; i < 2000 && !rx_rdy; i++) @(negedge clk);
    chk("R8 byte0", rx_data, 8'hC3);
    held = nlog;
    cyc(60);
    chk("R8 stretch", scl_low, 1);
    chk("R8 no overrun", nlog, held);
    pop_rx();
    chk("R8 rx_rdy clears", rx_rdy, 0);
    for (int i = 0; i < 2000 && !rx_rdy; i++) @(negedge clk);
    chk("R8 byte1", rx_data, 8'h5E);
    pop_rx();
    for (int i = 0; i < 2000 && !rx_rdy; i++) @(negedge clk);
    chk("R8 byte2", rx_data, 8'h81);
    wait_idle(); cyc(2);
    pop_rx();
    chk("R3 addr read", log_b[b0 % 64], 8'hB5);
    chk("R9 ack0", mack[m0 % 64], 0);
    chk("R9 ack1", mack[(m0 + 1) % 64], 0);
    chk("R9 nak last", mack[(m0 + 2) % 64], 1);
    chk("R10 read stop", nstop - s0, 1);
    chk("R10 read done", {idle, ccomp, scl_low, sda_low}, 4'b1100);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) rdata[i] = '0;
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_irq_mask();
    t_busy();
    t_addr_nack();
    t_write();
    t_data_nack();
    t_read();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule